// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block is the digital control for a frequency divider built around a two-modulus prescaler that divides by P or by P+1. It receives one strobe per prescaler output period, a 7-bit swallow value A and an 11-bit main count N. From these it drives a modulus-select line and emits one output strobe for every N prescaler periods. In the first A of those periods the prescaler is asked to divide by P+1, and in the remaining N−A periods it is asked to divide by P. The overall division from prescaler input to the output strobe is therefore P·N + A.

A and N are sampled only when the counters reload, which happens on the prescaler strobe that completes a cycle and once after reset. Changes made in the middle of a cycle wait for the next reload. Values that break the scheme are accepted but flagged: a main count below 16, or a swallow value larger than the main count.

Top module: `pswallow_divctl`

## Requirements
- R1: While reset is asserted, and on leaving reset before any reload, `mod_hi`, `div_out` and `cfg_err` are 0.
- R2: `mod_hi` is 1 (request P+1) exactly while the swallow count is nonzero. With the swallow value A, it covers the first A prescaler periods of each cycle, which is A·(P+1) clocks of a P/P+1 prescaler.
- R3: `div_out` pulses once for every N `pre_pulse` strobes, in the clock after the Nth strobe. The spacing between pulses is P·N + A input clocks.
- R4: With A = 0, `mod_hi` stays 0 for the whole cycle and the spacing is P·N.
- R5: With A = N, `mod_hi` stays 1 for the whole cycle, and the spacing is N·(P+1).
- R6: A change on `swallow_val` or `prog_val` during a cycle has no effect on `mod_hi`, `div_out` or `cfg_err` until the next reload.
- R7: At each reload `cfg_err` takes the value 1 when the loaded N is below 16 or the loaded A exceeds N, and 0 otherwise. It holds that value between reloads.
- R8: The full ranges work, with A up to 127 and N up to 2047.
- R9: `div_out` is high for exactly one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the prescaler strobe is synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_pulse | input | 1 | One-clock strobe per prescaler output period |
| swallow_val | input | 7 | Swallow value A, 0 to 127 |
| prog_val | input | 11 | Main count N, legal 16 to 2047 |
| mod_hi | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| div_out | output | 1 | One-clock strobe at the end of each divide cycle |
| cfg_err | output | 1 | Loaded values violate N ≥ 16 or A ≤ N |

## Verification
When A equals N, the last decrement of the swallow counter and the expiry of the main counter fall on the same prescaler strobe. The reload on that edge must win, so `mod_hi` never drops during the cycle. The sweep visits every A from 0 to N for several small N, which includes this case for each of them. The bench judges it by the number of clocks with `mod_hi` high, expected N·(P+1), and by the output spacing.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    // Registered outputs of the top-level control.
    typedef struct packed {
        logic div_out;
        logic cfg_err;
    } ctl_state_t;

    localparam int unsigned DEF_SW_W   = 7;
    localparam int unsigned DEF_PG_W   = 11;
    localparam int unsigned DEF_PG_MIN = 16;

endpackage

// File: rtl/dm_swallow_ctr.sv
module dm_swallow_ctr #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         nonzero
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (dec && (count_q != '0)) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign nonzero = (count_q != '0);

    // R2: the count moves only on a load or a strobe
    a_r2_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(count_q));

    // R2: once exhausted the count sits at zero until reloaded
    a_r2_sw_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_q == '0) |=> (count_q == '0));

endmodule

// File: rtl/dm_prog_ctr.sv
module dm_prog_ctr #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         last,
    output logic         empty
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (dec && (count_q != '0)) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign last  = (count_q == W'(1));
    assign empty = (count_q == '0);

    // R3: every strobe short of expiry takes exactly one off the count
    a_r3_pg_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && count_q > W'(1)) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/pswallow_divctl.sv
module pswallow_divctl
    import pswallow_pkg::*;
#(
    parameter int unsigned SW_W   = DEF_SW_W,
    parameter int unsigned PG_W   = DEF_PG_W,
    parameter int unsigned PG_MIN = DEF_PG_MIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pre_pulse,
    input  logic [SW_W-1:0] swallow_val,
    input  logic [PG_W-1:0] prog_val,
    output logic            mod_hi,
    output logic            div_out,
    output logic            cfg_err
);

    localparam int unsigned CMP_W = (SW_W > PG_W) ? SW_W : PG_W;

    ctl_state_t st_d, st_q;
    logic       pg_last, pg_empty;
    logic       wrap, reload;
    logic [CMP_W-1:0] a_ext, n_ext;

    // A cycle ends on the strobe that consumes the last main count;
    // an empty main counter (after reset) loads without an output strobe.
    assign wrap   = pre_pulse && pg_last;
    assign reload = wrap || pg_empty;
    assign a_ext  = CMP_W'(swallow_val);
    assign n_ext  = CMP_W'(prog_val);

    dm_swallow_ctr #(.W(SW_W)) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .dec      (pre_pulse),
        .load_val (swallow_val),
        .nonzero  (mod_hi)
    );

    dm_prog_ctr #(.W(PG_W)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .dec      (pre_pulse),
        .load_val (prog_val),
        .last     (pg_last),
        .empty    (pg_empty)
    );

    always_comb begin
        st_d         = st_q;
        st_d.div_out = wrap;
        if (reload) begin
            st_d.cfg_err = (n_ext < CMP_W'(PG_MIN)) || (a_ext > n_ext);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_out = st_q.div_out;
    assign cfg_err = st_q.cfg_err;

    // R3: an output strobe always follows a prescaler strobe
    a_r3_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> $past(pre_pulse));

    // R7: the error flag changes only when the counters reload
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(cfg_err));

    // R6: between strobes inside a cycle the modulus request is frozen
    a_r6_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_pulse && !pg_empty) |=> $stable(mod_hi));

endmodule

// File: tb/tb_pswallow_divctl.sv
module tb_pswallow_divctl;

    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_pulse = 1'b0;
    logic [6:0] swallow_val = 7'd3;
    logic [10:0] prog_val = 11'd16;
    logic       mod_hi, div_out, cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cur_a = 3, cur_n = 16;

    always #5 clk = ~clk;

    pswallow_divctl dut (
        .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse),
        .swallow_val(swallow_val), .prog_val(prog_val),
        .mod_hi(mod_hi), .div_out(div_out), .cfg_err(cfg_err)
    );

    // P/P+1 prescaler model: strobe after P or P+1 clocks per mod_hi
    int pcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pcnt <= 0;
            pre_pulse <= 1'b0;
        end else if (pcnt + 1 == (mod_hi ? P + 1 : P)) begin
            pcnt <= 0;
            pre_pulse <= 1'b1;
        end else begin
            pcnt <= pcnt + 1;
            pre_pulse <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge where div_out is high; returns at the next one.
    task automatic measure(output int len, output int hi);
        len = 0;
        hi = 0;
        do begin
            if (mod_hi) hi++;
            len++;
            @(negedge clk);
            if (len == 1) chk(!div_out, "R9 width", int'(div_out), 0);
        end while (!div_out);
    endtask

    task automatic do_cfg(input int a, input int n);
        int len, hi;
        bit old_ok, new_ok;
        old_ok = (cur_n >= 16) && (cur_a <= cur_n);
        new_ok = (n >= 16) && (a <= n);
        swallow_val = 7'(a);
        prog_val = 11'(n);
        @(negedge clk);
        chk(cfg_err == !old_ok, "R6 err hold", int'(cfg_err), int'(!old_ok));
        measure(len, hi);
        len++;
        if (old_ok)
            chk(len == P * cur_n + cur_a, "R6 old cycle", len, P * cur_n + cur_a);
        chk(cfg_err == !new_ok, "R7 flag", int'(cfg_err), int'(!new_ok));
        cur_a = a;
        cur_n = n;
        if (new_ok) begin
            measure(len, hi);
            chk(len == P * n + a, "R3 spacing", len, P * n + a);
            chk(hi == a * (P + 1), "R2 high clocks", hi, a * (P + 1));
            if (a == 0) chk(hi == 0, "R4 no swallow", hi, 0);
            if (a == n) chk(hi == len, "R5 all high", hi, len);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mod_hi && !div_out && !cfg_err, "R1 reset", int'({mod_hi, div_out, cfg_err}), 0);
        rst_n = 1'b1;
        chk(!mod_hi && !div_out && !cfg_err, "R1 release", int'({mod_hi, div_out, cfg_err}), 0);
        do @(negedge clk); while (!div_out);
        for (int n = 16; n <= 22; n++) begin
            for (int a = 0; a <= n; a++) do_cfg(a, n);
        end
        do_cfg(127, 127);   // R5 at the top of the swallow range
        do_cfg(0, 2047);    // R8
        do_cfg(127, 2047);  // R8
        do_cfg(30, 20);     // R7 A above N
        do_cfg(5, 20);
        do_cfg(3, 10);      // R7 N below minimum
        do_cfg(4, 40);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule